// File: doc/BRIEF.md
# In-Order Retirement Buffer with Precise Exceptions

This block is the circular reorder buffer of an out-of-order core. Dispatch writes one entry per cycle at the tail, in program order, and receives the slot index to tag the operation with. Execution units later report completion against that index in any order, together with a fault flag and fault code, or a branch-mispredict flag. Entries leave from the head, strictly in order, up to two per cycle, and each retirement reports the destination architectural register and physical tag so the committed mapping can be updated.

Exceptional events are never acted on when they are detected: they are only noted in the entry. A fault is handled when its entry reaches the head: everything older has already left, the faulting operation does not commit, and every younger entry is discarded. A mispredicted branch commits and then discards everything behind it, all of which is wrong-path work. A pending interrupt request is taken at the next retirement: the operation retiring in that cycle commits, and everything behind it is discarded. Each of these raises a one-cycle flush pulse with a redirect cause, and the buffer is empty in the following cycle.

Top module: `retire_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, `ret0_valid`, `ret1_valid` and `flush` are 0 and `redirect_cause` is 0.
- R2: Each accepted allocation takes the slot shown on `alloc_idx`; slots are handed out in increasing order modulo 16. With 16 entries held `alloc_ready` is 0 and an allocation request is not accepted.
- R3: The head entry retires (`ret0_valid`=1, with its own `ret0_arch` and `ret0_ptag`) only once it has completed; no younger entry retires ahead of an incomplete head, however many younger entries have completed.
- R4: `ret1_valid` reports the entry just behind the head and is 1 only when the head retires normally and that entry has completed with neither fault nor mispredict flag; it is never 1 without `ret0_valid`.
- R5: A completed head marked faulting does not retire: `ret0_valid`=0, `flush`=1, `redirect_cause`=1 and `fault_code` carries the code written at completion.
- R6: A completed head marked mispredicted retires with `ret0_valid`=1 and raises `flush`=1 with `redirect_cause`=2; the entry behind it does not retire in that cycle.
- R7: With `irq_req` high in a cycle where the head retires normally, only the head retires, and `flush`=1 with `redirect_cause`=3. With `irq_req` high while nothing retires there is no flush.
- R8: Causes at the same head rank fault over mispredict over interrupt.
- R9: During the flush cycle `alloc_ready` is 0; in the cycle after a flush the buffer is empty (no retirement, `alloc_ready`=1, `alloc_idx`=0), and completions written during the flush cycle leave nothing behind.
- R10: A completion addressed to a slot that holds no entry has no effect: an entry allocated into that slot later is still incomplete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_arch | input | 5 | Destination architectural register of the new entry |
| alloc_ptag | input | 7 | Physical tag of the new entry |
| alloc_ready | output | 1 | Allocation accepted this cycle if requested |
| alloc_idx | output | 4 | Slot the new entry takes |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | 4 | Slot being completed |
| cmp_fault | input | 1 | Operation faulted |
| cmp_code | input | 4 | Fault type |
| cmp_mispred | input | 1 | Branch was mispredicted |
| irq_req | input | 1 | Pending interrupt request (level) |
| ret0_valid | output | 1 | Head entry retires |
| ret0_arch | output | 5 | Head destination register |
| ret0_ptag | output | 7 | Head physical tag |
| ret1_valid | output | 1 | Second entry retires |
| ret1_arch | output | 5 | Second entry destination register |
| ret1_ptag | output | 7 | Second entry physical tag |
| flush | output | 1 | One-cycle flush of all younger entries |
| redirect_cause | output | 2 | 0 none, 1 fault, 2 mispredict, 3 interrupt |
| fault_code | output | 4 | Fault type when cause is 1, else 0 |

## Verification
The two functions that share a cycle are retirement selection and event arbitration: a head that both retires and carries an event, or a completed head met by an interrupt request, or a head with both fault and mispredict flags while an interrupt is pending. The bench provokes each case by completing the head with the chosen flags and raising `irq_req` in the cycle the head becomes eligible, and judges that only the expected slots commit, the cause follows the fault-mispredict-interrupt ranking, and the following cycle starts from an empty buffer at slot 0.

// File: rtl/retq_pkg.sv
// Shared types of the retirement buffer.
// Assumes nothing beyond IEEE 1800-2017.
package retq_pkg;

    // Redirect cause reported with a flush pulse
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_FAULT  = 2'd1,
        CAUSE_BRANCH = 2'd2,
        CAUSE_IRQ    = 2'd3
    } cause_e;

    // Per-slot status as seen by the retire selector
    typedef struct packed {
        logic live;
        logic done;
        logic fault;
        logic mispred;
    } slot_stat_t;

endpackage

// File: rtl/retq_ptrs.sv
// Head/tail pointers with an extra wrap bit.
// Assumes DEPTH is a power of two; at most one push and two pops per cycle.
// A flush returns both pointers to zero on the next edge.
module retq_ptrs #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [1:0]       pop_n,
    input  logic             flush,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [PTR_W-1:0] occupancy,
    output logic             full
);

    logic [PTR_W-1:0] head_q, tail_q;

    // Advance the pointers, or clear them on reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + PTR_W'(1);
            head_q <= head_q + PTR_W'(pop_n);
        end
    end

    // Derive slot indices, fill level and the full condition
    always_comb begin
        head_idx  = head_q[IDX_W-1:0];
        tail_idx  = tail_q[IDX_W-1:0];
        occupancy = tail_q - head_q;
        full      = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                    (head_q[IDX_W] != tail_q[IDX_W]);
    end

    // R2: fill level never exceeds the slot count
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= PTR_W'(DEPTH));

    // R3: never retire more entries than are held
    p_pop_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(pop_n) <= occupancy);

endmodule

// File: rtl/retq_store.sv
// Slot storage: live/done/fault/mispredict flags plus payload per slot.
// Assumes allocation only targets a free slot and cleared slots start at
// the read base; completions to free slots are dropped.
module retq_store
    import retq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ARCH_W = 5,
    parameter int PTAG_W = 7,
    parameter int CODE_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ARCH_W-1:0] wr_arch,
    input  logic [PTAG_W-1:0] wr_ptag,
    input  logic              cmp_en,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic              cmp_fault,
    input  logic [CODE_W-1:0] cmp_code,
    input  logic              cmp_mispred,
    input  logic [1:0]        clr_n,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic              flush,
    output slot_stat_t        stat0,
    output slot_stat_t        stat1,
    output logic [ARCH_W-1:0] arch0,
    output logic [PTAG_W-1:0] ptag0,
    output logic [CODE_W-1:0] code0,
    output logic [ARCH_W-1:0] arch1,
    output logic [PTAG_W-1:0] ptag1
);

    logic [DEPTH-1:0]  live_q, done_q, fault_q, mis_q;
    logic [ARCH_W-1:0] arch_q [DEPTH];
    logic [PTAG_W-1:0] ptag_q [DEPTH];
    logic [CODE_W-1:0] code_q [DEPTH];
    logic [IDX_W-1:0]  next_idx;

    assign next_idx = base_idx + IDX_W'(1);

    // Update slot flags: allocate, retire-clear, or record completion
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            live_q  <= '0;
            done_q  <= '0;
            fault_q <= '0;
            mis_q   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    live_q[i]  <= 1'b1;
                    done_q[i]  <= 1'b0;
                    fault_q[i] <= 1'b0;
                    mis_q[i]   <= 1'b0;
                end else if ((clr_n != 2'd0 && base_idx == IDX_W'(i)) ||
                             (clr_n == 2'd2 && next_idx == IDX_W'(i))) begin
                    live_q[i] <= 1'b0;
                    done_q[i] <= 1'b0;
                end else if (cmp_en && cmp_idx == IDX_W'(i) && live_q[i]) begin
                    done_q[i]  <= 1'b1;
                    fault_q[i] <= cmp_fault;
                    mis_q[i]   <= cmp_mispred;
                end
            end
        end
    end

    // Capture payload: register and tag at allocation, code at completion
    always_ff @(posedge clk) begin
        if (wr_en) begin
            arch_q[wr_idx] <= wr_arch;
            ptag_q[wr_idx] <= wr_ptag;
        end
        if (cmp_en) code_q[cmp_idx] <= cmp_code;
    end

    // Read the head slot and the slot behind it
    always_comb begin
        stat0 = {live_q[base_idx], done_q[base_idx], fault_q[base_idx], mis_q[base_idx]};
        stat1 = {live_q[next_idx], done_q[next_idx], fault_q[next_idx], mis_q[next_idx]};
        arch0 = arch_q[base_idx];
        ptag0 = ptag_q[base_idx];
        code0 = code_q[base_idx];
        arch1 = arch_q[next_idx];
        ptag1 = ptag_q[next_idx];
    end

    // R2: allocation never lands on an occupied slot
    p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !live_q[wr_idx]);

    // R10: a slot can only be complete while it holds an entry
    p_done_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q & ~live_q) == '0);

    // R3: whatever is cleared from the head had completed
    p_retire_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n != 2'd0) |-> (live_q[base_idx] && done_q[base_idx]));

endmodule

// File: rtl/retq_select.sv
// Retire selector: decides which of the two oldest slots commit and
// whether a flush is raised, with fault over mispredict over interrupt.
// Purely combinational; assumes stat1 describes the slot behind stat0.
module retq_select
    import retq_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  slot_stat_t        stat0,
    input  slot_stat_t        stat1,
    input  logic              irq,
    input  logic [CODE_W-1:0] code0,
    output logic              ret0,
    output logic              ret1,
    output logic              flush,
    output cause_e            cause,
    output logic [CODE_W-1:0] code_out,
    output logic [1:0]        pop_n
);

    // Choose retiring slots and the redirect event
    always_comb begin
        ret0     = 1'b0;
        ret1     = 1'b0;
        flush    = 1'b0;
        cause    = CAUSE_NONE;
        code_out = '0;
        if (stat0.live && stat0.done) begin
            if (stat0.fault) begin
                flush    = 1'b1;
                cause    = CAUSE_FAULT;
                code_out = code0;
            end else begin
                ret0 = 1'b1;
                if (stat0.mispred) begin
                    flush = 1'b1;
                    cause = CAUSE_BRANCH;
                end else if (irq) begin
                    flush = 1'b1;
                    cause = CAUSE_IRQ;
                end else begin
                    ret1 = stat1.live && stat1.done && !stat1.fault && !stat1.mispred;
                end
            end
        end
        pop_n = {1'b0, ret0} + {1'b0, ret1};
    end

endmodule

// File: rtl/retire_buffer.sv
// Top of the in-order retirement buffer: 16-slot circular queue, one
// allocation per cycle, out-of-order completion, two-wide in-order
// retirement and precise flush on fault, mispredict or interrupt.
// Assumes completions address slots returned on alloc_idx.
module retire_buffer
    import retq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ARCH_W = 5,
    parameter int PTAG_W = 7,
    parameter int CODE_W = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ARCH_W-1:0] alloc_arch,
    input  logic [PTAG_W-1:0] alloc_ptag,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic              cmp_fault,
    input  logic [CODE_W-1:0] cmp_code,
    input  logic              cmp_mispred,
    input  logic              irq_req,
    output logic              ret0_valid,
    output logic [ARCH_W-1:0] ret0_arch,
    output logic [PTAG_W-1:0] ret0_ptag,
    output logic              ret1_valid,
    output logic [ARCH_W-1:0] ret1_arch,
    output logic [PTAG_W-1:0] ret1_ptag,
    output logic              flush,
    output logic [1:0]        redirect_cause,
    output logic [CODE_W-1:0] fault_code
);

    logic [IDX_W-1:0] head_idx, tail_idx;
    logic [PTR_W-1:0] occupancy;
    logic             full, push;
    logic [1:0]       pop_n;
    slot_stat_t       stat0, stat1;
    logic [CODE_W-1:0] code0;
    cause_e           cause;

    // Accept allocation when a slot is free and no flush is under way
    always_comb begin
        alloc_ready    = !full && !flush;
        push           = alloc_valid && alloc_ready;
        alloc_idx      = tail_idx;
        redirect_cause = cause;
    end

    retq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .push(push), .pop_n(pop_n), .flush(flush),
        .head_idx(head_idx), .tail_idx(tail_idx), .occupancy(occupancy), .full(full)
    );

    retq_store #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .PTAG_W(PTAG_W), .CODE_W(CODE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push), .wr_idx(tail_idx), .wr_arch(alloc_arch), .wr_ptag(alloc_ptag),
        .cmp_en(cmp_valid), .cmp_idx(cmp_idx), .cmp_fault(cmp_fault),
        .cmp_code(cmp_code), .cmp_mispred(cmp_mispred),
        .clr_n(pop_n), .base_idx(head_idx), .flush(flush),
        .stat0(stat0), .stat1(stat1), .arch0(ret0_arch), .ptag0(ret0_ptag),
        .code0(code0), .arch1(ret1_arch), .ptag1(ret1_ptag)
    );

    retq_select #(.CODE_W(CODE_W)) u_sel (
        .stat0(stat0), .stat1(stat1), .irq(irq_req), .code0(code0),
        .ret0(ret0_valid), .ret1(ret1_valid), .flush(flush), .cause(cause),
        .code_out(fault_code), .pop_n(pop_n)
    );

    // R9: the cycle after a flush starts from an empty queue
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0) && !ret0_valid);

    // R4: the second slot never commits alone
    p_pair_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ret1_valid |-> ret0_valid);

    // R2: a full queue refuses allocation
    p_full_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == PTR_W'(DEPTH)) |-> !alloc_ready);

endmodule

// File: tb/retire_buffer_test.sv
module retire_buffer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0;
    logic [4:0] alloc_arch = '0;
    logic [6:0] alloc_ptag = '0;
    logic       alloc_ready;
    logic [3:0] alloc_idx;
    logic       cmp_valid = 1'b0;
    logic [3:0] cmp_idx = '0;
    logic       cmp_fault = 1'b0;
    logic [3:0] cmp_code = '0;
    logic       cmp_mispred = 1'b0;
    logic       irq_req = 1'b0;
    logic       ret0_valid, ret1_valid, flush;
    logic [4:0] ret0_arch, ret1_arch;
    logic [6:0] ret0_ptag, ret1_ptag;
    logic [1:0] redirect_cause;
    logic [3:0] fault_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    retire_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_arch(alloc_arch), .alloc_ptag(alloc_ptag),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_fault(cmp_fault),
        .cmp_code(cmp_code), .cmp_mispred(cmp_mispred), .irq_req(irq_req),
        .ret0_valid(ret0_valid), .ret0_arch(ret0_arch), .ret0_ptag(ret0_ptag),
        .ret1_valid(ret1_valid), .ret1_arch(ret1_arch), .ret1_ptag(ret1_ptag),
        .flush(flush), .redirect_cause(redirect_cause), .fault_code(fault_code)
    );

    // Stimulus row: alloc, completion fields, irq | expected ret0 ret1 flush cause
    typedef struct packed {
        logic       av;
        logic       cv;
        logic [3:0] ci;
        logic       cf;
        logic       cm;
        logic       irq;
        logic       r0;
        logic       r1;
        logic       fl;
        logic [1:0] cz;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        {1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        {1'b0, 1'b1, 4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2},
        {1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b0, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1},
        {1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3},
        {1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}
    };

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    // Wait for a falling edge and drive one cycle of inputs
    task automatic put(input bit av, input logic [4:0] arch, input logic [6:0] ptag,
                       input bit cv, input logic [3:0] ci, input bit cf,
                       input logic [3:0] cc, input bit cm, input bit irq);
        @(negedge clk);
        alloc_valid = av; alloc_arch = arch; alloc_ptag = ptag;
        cmp_valid = cv; cmp_idx = ci; cmp_fault = cf; cmp_code = cc;
        cmp_mispred = cm; irq_req = irq;
    endtask

    task automatic idle();
        put(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        alloc_valid = 1'b0; cmp_valid = 1'b0; irq_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        #1;
        // R1: reset state
        check(alloc_ready && alloc_idx == 4'd0 && !ret0_valid && !ret1_valid &&
              !flush && redirect_cause == 2'd0,
              $sformatf("R1 reset: ready=%b idx=%0d r0=%b r1=%b fl=%b cause=%0d exp 1 0 0 0 0 0",
                        alloc_ready, alloc_idx, ret0_valid, ret1_valid, flush, redirect_cause));

        // Table walk: R3 R4 R5 R6 R7 R9 retire and flush sequence
        for (int v = 0; v < NV; v++) begin
            put(VECS[v].av, 5'(v + 1), 7'(v + 20), VECS[v].cv, VECS[v].ci,
                VECS[v].cf, 4'(v), VECS[v].cm, VECS[v].irq);
            #1;
            check(ret0_valid == VECS[v].r0 && ret1_valid == VECS[v].r1 &&
                  flush == VECS[v].fl && redirect_cause == VECS[v].cz,
                  $sformatf("R3/R7 table row %0d: r0 r1 fl cause = %b %b %b %0d exp %b %b %b %0d",
                            v, ret0_valid, ret1_valid, flush, redirect_cause,
                            VECS[v].r0, VECS[v].r1, VECS[v].fl, VECS[v].cz));
        end

        // R2 fill all slots in order, then refuse one more
        do_reset();
        for (int k = 0; k < 16; k++) begin
            put(1'b1, 5'(k + 1), 7'(k + 40), 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
            #1;
            check(alloc_ready && alloc_idx == 4'(k),
                  $sformatf("R2 alloc %0d: ready=%b idx=%0d exp 1 %0d", k, alloc_ready, alloc_idx, k));
        end
        put(1'b1, 5'd31, 7'd127, 1'b1, 4'd15, 1'b0, '0, 1'b0, 1'b0);
        #1;
        check(!alloc_ready, $sformatf("R2 full: ready=%b exp 0", alloc_ready));
        // R3 younger completions cannot pass an incomplete head
        for (int k = 14; k >= 0; k--) begin
            put(1'b0, '0, '0, 1'b1, 4'(k), 1'b0, '0, 1'b0, 1'b0);
            #1;
            check(!ret0_valid, $sformatf("R3 head pending, cmp %0d: r0=%b exp 0", k, ret0_valid));
        end
        // R4 two per cycle, in program order
        for (int p = 0; p < 8; p++) begin
            idle();
            #1;
            check(ret0_valid && ret1_valid && ret0_arch == 5'(2*p + 1) &&
                  ret1_arch == 5'(2*p + 2) && ret0_ptag == 7'(2*p + 40) &&
                  ret1_ptag == 7'(2*p + 41),
                  $sformatf("R4 pair %0d: v=%b%b arch=%0d,%0d ptag=%0d,%0d exp 11 %0d,%0d %0d,%0d",
                            p, ret0_valid, ret1_valid, ret0_arch, ret1_arch, ret0_ptag, ret1_ptag,
                            2*p + 1, 2*p + 2, 2*p + 40, 2*p + 41));
        end
        idle();
        #1;
        check(!ret0_valid && alloc_ready,
              $sformatf("R2 drained, refused entry absent: r0=%b ready=%b exp 0 1", ret0_valid, alloc_ready));

        // R4 second slot faulting waits; R5 it then faults at the head
        do_reset();
        put(1'b1, 5'd3, 7'd50, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
        put(1'b1, 5'd4, 7'd51, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
        put(1'b0, '0, '0, 1'b1, 4'd1, 1'b1, 4'd9, 1'b0, 1'b0);
        put(1'b0, '0, '0, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0);
        idle();
        #1;
        check(ret0_valid && !ret1_valid && !flush && ret0_arch == 5'd3,
              $sformatf("R4 faulting second: r0=%b r1=%b fl=%b arch=%0d exp 1 0 0 3",
                        ret0_valid, ret1_valid, flush, ret0_arch));
        put(1'b0, '0, '0, 1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 1'b0);
        #1;
        check(!ret0_valid && flush && redirect_cause == 2'd1 && fault_code == 4'd9,
              $sformatf("R5 fault at head: r0=%b fl=%b cause=%0d code=%0d exp 0 1 1 9",
                        ret0_valid, flush, redirect_cause, fault_code));
        idle();
        #1;
        check(!ret0_valid && alloc_ready && alloc_idx == 4'd0 && !flush,
              $sformatf("R9 after flush: r0=%b ready=%b idx=%0d fl=%b exp 0 1 0 0",
                        ret0_valid, alloc_ready, alloc_idx, flush));

        // R8 fault beats mispredict and interrupt; R9 no alloc in flush cycle
        do_reset();
        put(1'b1, 5'd5, 7'd60, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
        put(1'b0, '0, '0, 1'b1, 4'd0, 1'b1, 4'd6, 1'b1, 1'b0);
        put(1'b1, 5'd9, 7'd61, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
        #1;
        check(!ret0_valid && flush && redirect_cause == 2'd1 && fault_code == 4'd6,
              $sformatf("R8 fault first: r0=%b fl=%b cause=%0d code=%0d exp 0 1 1 6",
                        ret0_valid, flush, redirect_cause, fault_code));
        check(!alloc_ready, $sformatf("R9 flush cycle ready=%b exp 0", alloc_ready));
        // R6/R8 mispredict beats interrupt and holds back the second slot
        put(1'b1, 5'd7, 7'd62, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
        #1;
        check(alloc_idx == 4'd0 && !ret0_valid,
              $sformatf("R9 restart idx=%0d r0=%b exp 0 0", alloc_idx, ret0_valid));
        put(1'b1, 5'd8, 7'd63, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
        put(1'b0, '0, '0, 1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 1'b0);
        put(1'b0, '0, '0, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0);
        put(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
        #1;
        check(ret0_valid && !ret1_valid && flush && redirect_cause == 2'd2 && ret0_arch == 5'd7,
              $sformatf("R6 mispredict: r0=%b r1=%b fl=%b cause=%0d arch=%0d exp 1 0 1 2 7",
                        ret0_valid, ret1_valid, flush, redirect_cause, ret0_arch));

        // R10 completion to an empty slot is dropped
        do_reset();
        put(1'b0, '0, '0, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0);
        put(1'b1, 5'd12, 7'd70, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
        idle();
        #1;
        check(!ret0_valid, $sformatf("R10 stale completion: r0=%b exp 0", ret0_valid));
        idle();
        #1;
        check(!ret0_valid, $sformatf("R10 still pending: r0=%b exp 0", ret0_valid));
        put(1'b0, '0, '0, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0);
        idle();
        #1;
        check(ret0_valid && ret0_arch == 5'd12 && ret0_ptag == 7'd70,
              $sformatf("R3 real completion: r0=%b arch=%0d ptag=%0d exp 1 12 70",
                        ret0_valid, ret0_arch, ret0_ptag));

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule